// File: doc/BRIEF.md
# Serial Port Status Register with Read-Armed Flag Clearing

This block holds the 8-bit status and control byte of a serial port. Transmit and receive engines raise five event flags with one-cycle set pulses. The CPU clears a flag by writing 0 to it, but the write only takes effect if the CPU has already read that flag while it was 1. As a result, software cannot lose an event that arrives between its read and its write. Two further bits mirror status coming from the engines and cannot be written. The lowest bit is a plain control bit that software owns completely.

Each of the five event flags is tracked by its own three-state machine:

- `FL_CLEAR`: the flag reads 0.
- `FL_SET_IDLE`: the flag reads 1 but is not armed for clearing.
- `FL_SET_ARMED`: the flag reads 1 and a read has armed it for clearing.

The transitions are:

- set: any state goes to `FL_SET_IDLE` on a hardware set pulse. This also disarms an armed flag.
- arm: `FL_SET_IDLE` goes to `FL_SET_ARMED` when a CPU read occurs.
- clear: `FL_SET_ARMED` goes to `FL_CLEAR` when a write puts 0 on that bit.
- reinit: reset or standby returns every flag to its initial state.

A read in `FL_CLEAR` does nothing. A write in `FL_CLEAR` or `FL_SET_IDLE` does nothing.

Top module: `sstat_reg`

## Requirements
- R1: Bit layout of `rd_data`:
  - Bit 7 is transmit-empty (`flag_set[4]`).
  - Bit 6 is receive-full (`flag_set[3]`).
  - Bit 5 is overrun (`flag_set[2]`).
  - Bit 4 is framing error (`flag_set[1]`).
  - Bit 3 is parity error (`flag_set[0]`).
  - Bit 2 is transmit end.
  - Bit 1 is the received multiprocessor bit.
  - Bit 0 is the multiprocessor-bit-transmit control.
  - `flags_o[k]` equals `rd_data[k+3]`, and `mp_tx_o` equals `rd_data[0]`.
- R2: After reset, `rd_data` reads 0x84, provided `tx_end_in` is 1 and `mp_rx_in` is 0.
- R3: A cycle with `standby` high reinitializes the register to 0x84, whatever the input values. It also drops any arming, so a later write of 0 without a new read does not clear transmit-empty.
- R4: Writing 1 to a flag bit (bits 7 to 3) that is 0 leaves it 0.
- R5: Writing 0 to a set flag clears it only if that flag is armed. Two cases leave the flag unarmed:
  - the flag was never read while it was 1;
  - the only read happened while the flag was still 0.
- R6: A read of a flag while it is 1, followed by a later write with 0 in that bit, clears the flag on that write's clock edge. A write with 1 in that bit leaves the flag set and still armed.
- R7: Bits 2 and 1 ignore CPU writes. Each clock edge outside standby loads them from `tx_end_in` and `mp_rx_in`.
- R8: Bit 0 takes `wr_data[0]` on each write.
- R9: A set pulse wins over a clear in the same cycle. It also disarms the flag, so another read is needed before a write of 0 can clear it.
- R10: `rd_data` is combinational from the current state, so a read strobe returns the value of the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Synchronous reinitialize while high |
| rd_en | input | 1 | CPU read strobe (arms flags that read as 1) |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Current register value |
| flag_set | input | 5 | Hardware set pulses for bits 3..7 (index k maps to bit k+3) |
| tx_end_in | input | 1 | Transmit-end status from the transmitter |
| mp_rx_in | input | 1 | Received multiprocessor bit from the receiver |
| flags_o | output | 5 | Current flag levels, bits 7..3 |
| mp_tx_o | output | 1 | Multiprocessor-bit-transmit control |

## Verification
The clearing path is tried with several orderings:

- A write of 0 with no read tells the arming rule apart from a plain write-0-to-clear register.
- A read followed by a write of 0 shows the intended clear.
- A read taken while the flag was still 0, followed by a set and a write of 0, catches an arm that ignores the flag value.
- A set pulse in the same cycle as an armed clear, followed by a write of 0 with no new read, separates set-wins from clear-wins and shows that the set disarms the flag.

A mixed write of 0xA0 to two armed flags shows that each bit is cleared on its own. Writes of 1 to cleared flags, writes to the read-only bits and a standby with flags set cover the remaining corners.

// File: rtl/sstat_pkg.sv
package sstat_pkg;
    localparam int          REG_W     = 8;
    localparam int          FLAG_N    = 5;
    localparam int          FLAG_LSB  = 3;
    localparam int          TEND_POS  = 2;
    localparam int          MPBR_POS  = 1;
    localparam int          MPBT_POS  = 0;
    localparam logic [7:0]  RESET_VAL = 8'h84;

    typedef enum logic [1:0] {
        FL_CLEAR     = 2'd0,
        FL_SET_IDLE  = 2'd1,
        FL_SET_ARMED = 2'd2
    } flag_st_e;
endpackage

// File: rtl/sstat_flag.sv
module sstat_flag
    import sstat_pkg::*;
#(
    parameter bit INIT_SET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic set_evt,
    input  logic rd_hit,
    input  logic clr_req,
    output logic flag_o
);
    localparam flag_st_e INIT_ST = INIT_SET ? FL_SET_IDLE : FL_CLEAR;

    flag_st_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= INIT_ST;
        else if (standby) state_q <= INIT_ST;
        else              state_q <= state_d;
    end

    // next state: a set event takes priority over arming and clearing
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: begin
                if (set_evt) state_d = FL_SET_IDLE;
            end
            FL_SET_IDLE: begin
                if (set_evt)     state_d = FL_SET_IDLE;
                else if (rd_hit) state_d = FL_SET_ARMED;
            end
            FL_SET_ARMED: begin
                if (set_evt)      state_d = FL_SET_IDLE;
                else if (clr_req) state_d = FL_CLEAR;
            end
            default: state_d = INIT_ST;
        endcase
    end

    // output
    always_comb begin
        flag_o = (state_q != FL_CLEAR);
    end
endmodule

// File: rtl/sstat_ctl.sv
module sstat_ctl
    import sstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic tx_end_in,
    input  logic mp_rx_in,
    output logic tend_o,
    output logic mpbr_o,
    output logic mpbt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tend_o <= RESET_VAL[TEND_POS];
            mpbr_o <= RESET_VAL[MPBR_POS];
            mpbt_o <= RESET_VAL[MPBT_POS];
        end else if (standby) begin
            tend_o <= RESET_VAL[TEND_POS];
            mpbr_o <= RESET_VAL[MPBR_POS];
            mpbt_o <= RESET_VAL[MPBT_POS];
        end else begin
            tend_o <= tx_end_in;
            mpbr_o <= mp_rx_in;
            if (wr_en) mpbt_o <= wr_bit;
        end
    end
endmodule

// File: rtl/sstat_reg.sv
module sstat_reg
    import sstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic [FLAG_N-1:0] flag_set,
    input  logic              tx_end_in,
    input  logic              mp_rx_in,
    output logic [FLAG_N-1:0] flags_o,
    output logic              mp_tx_o
);
    logic tend_q, mpbr_q, mpbt_q;

    for (genvar k = 0; k < FLAG_N; k++) begin : g_flag
        sstat_flag #(
            .INIT_SET (RESET_VAL[FLAG_LSB+k])
        ) u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .standby (standby),
            .set_evt (flag_set[k]),
            .rd_hit  (rd_en),
            .clr_req (wr_en && !wr_data[FLAG_LSB+k]),
            .flag_o  (flags_o[k])
        );
    end

    sstat_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .wr_en     (wr_en),
        .wr_bit    (wr_data[MPBT_POS]),
        .tx_end_in (tx_end_in),
        .mp_rx_in  (mp_rx_in),
        .tend_o    (tend_q),
        .mpbr_o    (mpbr_q),
        .mpbt_o    (mpbt_q)
    );

    always_comb begin
        rd_data = {flags_o, tend_q, mpbr_q, mpbt_q};
        mp_tx_o = mpbt_q;
    end
endmodule

// File: rtl/sstat_reg_chk.sv
module sstat_reg_chk
    import sstat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              standby,
    input logic              rd_en,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  rd_data,
    input logic [FLAG_N-1:0] flag_set,
    input logic              tx_end_in,
    input logic              mp_rx_in,
    input logic [FLAG_N-1:0] flags_o,
    input logic              mp_tx_o
);
    p_standby_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> rd_data == RESET_VAL);

    p_ro_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !standby |=> (rd_data[TEND_POS] == $past(tx_end_in)) &&
                     (rd_data[MPBR_POS] == $past(mp_rx_in)));

    p_ctl_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !standby) |=> mp_tx_o == $past(wr_data[MPBT_POS]));

    for (genvar k = 0; k < FLAG_N; k++) begin : g_chk
        p_no_write_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !standby && !flag_set[k] && !rd_data[FLAG_LSB+k])
            |=> !rd_data[FLAG_LSB+k]);

        p_clear_by_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(rd_data[FLAG_LSB+k]) && !$past(standby))
            |-> ($past(wr_en) && !$past(wr_data[FLAG_LSB+k])));

        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_set[k] && !standby) |=> rd_data[FLAG_LSB+k]);
    end
endmodule

bind sstat_reg sstat_reg_chk u_chk (.*);

// File: tb/sstat_reg_tb.sv
module sstat_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n, standby, rd_en, wr_en, tx_end_in, mp_rx_in, mp_tx_o;
    logic [7:0] wr_data, rd_data;
    logic [4:0] flag_set, flags_o;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sstat_reg u_dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd(output logic [7:0] v);
        rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic pulse(input logic [4:0] s);
        flag_set = s;
        @(negedge clk);
        flag_set = 5'b0;
    endtask

    task automatic t_reset;
        chk("R2 reset value", rd_data, 8'h84);
        chk("R1 flags_o mirrors bits 7..3", {3'b0, flags_o}, 8'h10);
        chk("R1 mp_tx_o mirrors bit 0", {7'b0, mp_tx_o}, 8'h00);
    endtask

    task automatic t_write_no_read;
        wr(8'h00);
        chk("R5 write 0 without read keeps flag", rd_data, 8'h84);
    endtask

    task automatic t_read_clear;
        logic [7:0] v;
        rd(v);
        chk("R10 read returns current value", v, 8'h84);
        wr(8'h00);
        chk("R6 read then write 0 clears", rd_data, 8'h04);
        pulse(5'b01100);
        chk("R1 receive-full and overrun set", rd_data, 8'h64);
        rd(v);
        wr(8'hA0);
        chk("R6 per-bit clear with mixed data", rd_data, 8'h24);
        wr(8'h00);
        chk("R6 flag stays armed after write of 1", rd_data, 8'h04);
    endtask

    task automatic t_write_one;
        wr(8'hF8);
        chk("R4 write 1 to cleared flags", rd_data, 8'h04);
    endtask

    task automatic t_read_zero_no_arm;
        logic [7:0] v;
        rd(v);
        pulse(5'b00001);
        chk("R1 parity flag set", rd_data, 8'h0C);
        wr(8'h00);
        chk("R5 read while 0 does not arm", rd_data, 8'h0C);
        rd(v);
        wr(8'h00);
        chk("R6 clear after proper read", rd_data, 8'h04);
    endtask

    task automatic t_ro_bits;
        wr(8'h06);
        chk("R7 write to read-only bits ignored", rd_data, 8'h04);
        tx_end_in = 1'b0; mp_rx_in = 1'b1;
        @(negedge clk);
        chk("R7 read-only bits follow inputs", rd_data, 8'h02);
        tx_end_in = 1'b1; mp_rx_in = 1'b0;
        @(negedge clk);
        chk("R7 read-only bits return", rd_data, 8'h04);
    endtask

    task automatic t_ctl_bit;
        wr(8'h01);
        chk("R8 control bit set", rd_data, 8'h05);
        chk("R8 mp_tx_o high", {7'b0, mp_tx_o}, 8'h01);
        wr(8'h00);
        chk("R8 control bit cleared", rd_data, 8'h04);
    endtask

    task automatic t_set_wins;
        logic [7:0] v;
        pulse(5'b00010);
        chk("R1 framing flag set", rd_data, 8'h14);
        rd(v);
        flag_set = 5'b00010; wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        flag_set = 5'b0; wr_en = 1'b0;
        chk("R9 set wins over clear", rd_data, 8'h14);
        wr(8'h00);
        chk("R9 set disarms flag", rd_data, 8'h14);
        rd(v);
        wr(8'h00);
        chk("R9 clear after new read", rd_data, 8'h04);
    endtask

    task automatic t_standby;
        logic [7:0] v;
        pulse(5'b01000);
        wr(8'h01);
        chk("R3 setup before standby", rd_data, 8'h45);
        rd(v);
        tx_end_in = 1'b0; mp_rx_in = 1'b1; standby = 1'b1;
        @(negedge clk);
        standby = 1'b0; tx_end_in = 1'b1; mp_rx_in = 1'b0;
        chk("R3 standby reinitializes", rd_data, 8'h84);
        wr(8'h00);
        chk("R3 standby drops arming", rd_data, 8'h84);
    endtask

    initial begin
        rst_n = 1'b0; standby = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        wr_data = 8'h00; flag_set = 5'b0; tx_end_in = 1'b1; mp_rx_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_no_read();
        t_read_clear();
        t_write_one();
        t_read_zero_no_arm();
        t_ro_bits();
        t_ctl_bit();
        t_set_wins();
        t_standby();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule